// File: doc/BRIEF.md
# Synchronous Burst SRAM Write Controller

This block is a synthesizable model of a pipelined synchronous burst SRAM with a small internal array of 18-bit words, each word split into two 9-bit byte lanes. Every control input is sampled on the rising edge of `clk`. An address can be loaded through either of two strobes. A processor-side strobe loads the address and starts a read. A controller-side strobe loads the address and accepts write data in the same cycle. After a load, cycles with no strobe continue the burst. An advance input either holds the current address or steps the two low address bits in linear order, wrapping after four beats.

Lane writes are decoded from a global write input, a byte-write enable and one strobe per lane. Reads return data one edge after the address is sampled. The read data leaves the block as a value plus a pad drive enable, so the pad ring builds the actual three-state driver.

Top module: `burst_sram_wr`

## Requirements
- R1: The device is selected only when `en0_n`=0, `en1`=1 and `en2_n`=0. If either strobe is low while the device is not selected, no address is loaded and nothing is written. The burst also ends, so the cycles after it write nothing until the next selected strobe.
- R2: Lane 0 is `wdata[8:0]`, controlled by `bw_n[0]`. Lane 1 is `wdata[17:9]`, controlled by `bw_n[1]`. With `gw_n`=0, both lanes are written whatever `bwe_n` and `bw_n` are. With `gw_n`=1 and `bwe_n`=0, each lane whose `bw_n` bit is 0 is written. With `gw_n`=1 and `bwe_n`=1, nothing is written.
- R3: A selected cycle with `lda_cpu_n`=0 loads `addr` and writes nothing, whatever the write inputs are.
- R4: A selected cycle with `lda_ctl_n`=0 and `lda_cpu_n`=1 loads `addr` and writes `wdata` to that address in the same cycle, following the R2 decode.
- R5: In a burst cycle with no strobe and `adv_n`=1, the address is held and any write goes to the held address.
- R6: In a burst cycle with no strobe and `adv_n`=0, the two low address bits first step by one modulo 4 while the upper bits stay fixed. Any write then goes to the stepped address.
- R7: When both strobes are low in the same cycle, the processor-side rule (R3) applies.
- R8: A selected load, or a burst cycle that writes nothing, registers a read of its address. With `oe_n`=0 on the next cycle, `rdata` shows that word and `rdata_oe`=1.
- R9: `rdata_oe` is 0 whenever `oe_n`=1. It is also 0 in the cycle after any write.
- R10: After reset, every word reads 0, no burst is active and `rdata_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | AW | Address sampled by either strobe |
| lda_cpu_n | input | 1 | Processor-side address strobe, active low |
| lda_ctl_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, both lanes, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | 2 | Per-lane write strobes, active low |
| en0_n | input | 1 | Chip enable, active low |
| en1 | input | 1 | Chip enable, active high |
| en2_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| wdata | input | 2*LW | Write data |
| rdata | output | 2*LW | Registered read data |
| rdata_oe | output | 1 | Pad drive enable; 0 means high impedance |

## Verification
The bound checker watches the address register on every cycle. It checks that a selected strobe loads the address, that a suspend holds it, that an advance steps only the low two bits, that a deselected strobe leaves the address alone and ends the burst, that a write cycle leaves the pad undriven, and that a processor load is followed by driven data. Which words end up holding which lane data can only be shown by the bench's scenarios. The bench replays single, burst, suspended, wrapped, restarted, prioritised, deselected and partial-lane writes, then reads the whole array back against a reference array built from hand-computed target addresses.

// File: rtl/burst_sram_wr.sv
module burst_sram_wr #(
  parameter int AW = 6,
  parameter int LW = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   addr,
  input  logic            lda_cpu_n,
  input  logic            lda_ctl_n,
  input  logic            adv_n,
  input  logic            gw_n,
  input  logic            bwe_n,
  input  logic [1:0]      bw_n,
  input  logic            en0_n,
  input  logic            en1,
  input  logic            en2_n,
  input  logic            oe_n,
  input  logic [2*LW-1:0] wdata,
  output logic [2*LW-1:0] rdata,
  output logic            rdata_oe
);
  localparam int DW    = 2 * LW;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] cur, eff;
  logic [1:0]    nxt_lo, lane_req, lane_we;
  logic          active, rd_valid;
  logic [DW-1:0] rd_q;
  logic          sel, strobe, go, rd_en;

  assign sel    = !en0_n && en1 && !en2_n;
  assign strobe = !lda_cpu_n || !lda_ctl_n;
  assign nxt_lo = adv_n ? cur[1:0] : cur[1:0] + 2'd1;
  assign eff    = strobe ? addr : {cur[AW-1:2], nxt_lo};
  assign go     = strobe ? sel : active;

  for (genvar l = 0; l < 2; l++) begin : g_lane
    assign lane_req[l] = !gw_n || (!bwe_n && !bw_n[l]);
  end

  assign lane_we  = (go && lda_cpu_n) ? lane_req : 2'b00;
  assign rd_en    = go && (lane_we == 2'b00);
  assign rdata    = rd_q;
  assign rdata_oe = !oe_n && rd_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      cur      <= '0;
      rd_valid <= 1'b0;
      rd_q     <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (strobe) active <= sel;
      if (go) cur <= eff;
      rd_valid <= rd_en;
      if (rd_en) rd_q <= mem[eff];
      for (int l = 0; l < 2; l++)
        if (lane_we[l]) mem[eff][l*LW +: LW] <= wdata[l*LW +: LW];
    end
  end
endmodule

// File: rtl/burst_sram_wr_chk.sv
module burst_sram_wr_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic          lda_cpu_n,
  input logic          lda_ctl_n,
  input logic          adv_n,
  input logic          en0_n,
  input logic          en1,
  input logic          en2_n,
  input logic          oe_n,
  input logic          rdata_oe,
  input logic [AW-1:0] cur,
  input logic          active,
  input logic [1:0]    lane_we
);
  logic sel, idle;
  assign sel  = !en0_n && en1 && !en2_n;
  assign idle = lda_cpu_n && lda_ctl_n;

  AST_CPU_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!lda_cpu_n && sel) |=> (cur == $past(addr))); // R3
  AST_CTL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (lda_cpu_n && !lda_ctl_n && sel) |=> (cur == $past(addr))); // R4
  AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (active && idle && adv_n) |=> $stable(cur)); // R5
  AST_ADV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (active && idle && !adv_n) |=> (cur[1:0] == $past(cur[1:0]) + 2'd1 &&
                                    cur[AW-1:2] == $past(cur[AW-1:2]))); // R6
  AST_DESEL_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && !sel) |=> ($stable(cur) && !active)); // R1
  AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_we != 2'b00) |=> !rdata_oe); // R9
  AST_CPU_READ_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!lda_cpu_n && sel) |=> (oe_n || rdata_oe)); // R8
endmodule

bind burst_sram_wr burst_sram_wr_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .lda_cpu_n(lda_cpu_n),
  .lda_ctl_n(lda_ctl_n), .adv_n(adv_n), .en0_n(en0_n), .en1(en1),
  .en2_n(en2_n), .oe_n(oe_n), .rdata_oe(rdata_oe), .cur(cur),
  .active(active), .lane_we(lane_we)
);

// File: tb/burst_sram_wr_bench.sv
module burst_sram_wr_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int LW = 9;
  localparam int DW = 2 * LW;
  localparam int NS = 26;

  typedef struct packed {
    logic [2:0]    en;
    logic          cpu_n, ctl_n, adv_n, gw_n, bwe_n;
    logic [1:0]    bw_n;
    logic [AW-1:0] a;
    logic [AW-1:0] ea;
    logic [1:0]    em;
  } vec_t;

  localparam vec_t TBL [NS] = '{
    '{3'b010,1'b0,1'b1,1'b1,1'b0,1'b1,2'b11,6'h04,6'h00,2'b00},
    '{3'b010,1'b1,1'b1,1'b1,1'b0,1'b1,2'b11,6'h00,6'h04,2'b11},
    '{3'b010,1'b1,1'b1,1'b0,1'b0,1'b1,2'b11,6'h00,6'h05,2'b11},
    '{3'b010,1'b1,1'b1,1'b1,1'b1,1'b1,2'b11,6'h00,6'h00,2'b00},
    '{3'b010,1'b1,1'b1,1'b1,1'b0,1'b1,2'b11,6'h00,6'h05,2'b11},
    '{3'b010,1'b1,1'b1,1'b0,1'b0,1'b1,2'b11,6'h00,6'h06,2'b11},
    '{3'b010,1'b1,1'b1,1'b0,1'b0,1'b1,2'b11,6'h00,6'h07,2'b11},
    '{3'b010,1'b1,1'b1,1'b0,1'b0,1'b1,2'b11,6'h00,6'h04,2'b11},
    '{3'b010,1'b1,1'b0,1'b1,1'b0,1'b1,2'b11,6'h0B,6'h0B,2'b11},
    '{3'b010,1'b1,1'b1,1'b0,1'b1,1'b0,2'b10,6'h00,6'h08,2'b01},
    '{3'b010,1'b1,1'b1,1'b0,1'b1,1'b0,2'b01,6'h00,6'h09,2'b10},
    '{3'b010,1'b1,1'b1,1'b0,1'b1,1'b0,2'b00,6'h00,6'h0A,2'b11},
    '{3'b010,1'b1,1'b1,1'b0,1'b0,1'b1,2'b11,6'h00,6'h0B,2'b11},
    '{3'b010,1'b1,1'b0,1'b1,1'b1,1'b1,2'b11,6'h10,6'h00,2'b00},
    '{3'b010,1'b1,1'b1,1'b1,1'b1,1'b0,2'b10,6'h00,6'h10,2'b01},
    '{3'b010,1'b0,1'b0,1'b1,1'b0,1'b1,2'b11,6'h20,6'h00,2'b00},
    '{3'b010,1'b1,1'b1,1'b1,1'b0,1'b1,2'b11,6'h00,6'h20,2'b11},
    '{3'b110,1'b1,1'b0,1'b1,1'b0,1'b1,2'b11,6'h30,6'h00,2'b00},
    '{3'b010,1'b1,1'b1,1'b0,1'b0,1'b1,2'b11,6'h00,6'h00,2'b00},
    '{3'b010,1'b1,1'b1,1'b1,1'b0,1'b1,2'b11,6'h00,6'h00,2'b00},
    '{3'b000,1'b1,1'b0,1'b1,1'b0,1'b1,2'b11,6'h2A,6'h00,2'b00},
    '{3'b011,1'b1,1'b0,1'b1,1'b0,1'b1,2'b11,6'h2B,6'h00,2'b00},
    '{3'b010,1'b0,1'b1,1'b1,1'b0,1'b1,2'b11,6'h31,6'h00,2'b00},
    '{3'b010,1'b1,1'b1,1'b0,1'b1,1'b0,2'b00,6'h00,6'h32,2'b11},
    '{3'b010,1'b1,1'b0,1'b1,1'b1,1'b0,2'b01,6'h3F,6'h3F,2'b10},
    '{3'b010,1'b1,1'b1,1'b0,1'b0,1'b1,2'b11,6'h00,6'h3C,2'b11}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] addr;
  logic lda_cpu_n, lda_ctl_n, adv_n, gw_n, bwe_n, en0_n, en1, en2_n, oe_n;
  logic [1:0] bw_n;
  logic [DW-1:0] wdata, rdata;
  logic rdata_oe;
  logic [DW-1:0] ref_mem [1 << AW];
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  burst_sram_wr #(.AW(AW), .LW(LW)) u_burst_sram_wr (
    .clk(clk), .rst_n(rst_n), .addr(addr), .lda_cpu_n(lda_cpu_n),
    .lda_ctl_n(lda_ctl_n), .adv_n(adv_n), .gw_n(gw_n), .bwe_n(bwe_n),
    .bw_n(bw_n), .en0_n(en0_n), .en1(en1), .en2_n(en2_n), .oe_n(oe_n),
    .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
  );

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drv(input vec_t v, input logic [DW-1:0] d, input logic oe);
    {en0_n, en1, en2_n} = v.en;
    lda_cpu_n = v.cpu_n; lda_ctl_n = v.ctl_n; adv_n = v.adv_n;
    gw_n = v.gw_n; bwe_n = v.bwe_n; bw_n = v.bw_n; addr = v.a;
    wdata = d; oe_n = oe;
  endtask

  function automatic vec_t rd_vec(input logic [AW-1:0] a);
    return '{3'b010, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 2'b11, a, 6'h00, 2'b00};
  endfunction

  function automatic vec_t cont_vec(input logic adv, input logic gw);
    return '{3'b010, 1'b1, 1'b1, adv, gw, 1'b1, 2'b11, 6'h00, 6'h00, 2'b00};
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < (1 << AW); i++) ref_mem[i] = '0;
    drv(cont_vec(1'b1, 1'b0), '1, 1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: continuation cycle right after reset drove a write; no burst active, no drive
    chk(rdata_oe == 1'b0, "R10 no drive after reset", {17'b0, rdata_oe}, '0);
    drv(rd_vec(6'h00), '0, 1'b0);
    @(negedge clk);
    chk(rdata_oe && rdata == '0, "R10 word 0 cleared and unwritten", rdata, '0);

    for (int i = 0; i < NS; i++) begin
      logic [DW-1:0] d;
      d = {9'(i * 37 + 3), 9'(i * 11 + 100)};
      drv(TBL[i], d, 1'b1);
      if (TBL[i].em[0]) ref_mem[TBL[i].ea][LW-1:0] = d[LW-1:0];
      if (TBL[i].em[1]) ref_mem[TBL[i].ea][DW-1:LW] = d[DW-1:LW];
      @(negedge clk);
      chk(rdata_oe == 1'b0, "R9 oe_n high keeps pad undriven", {17'b0, rdata_oe}, '0);
    end

    for (int a = 0; a < (1 << AW); a++) begin
      drv(rd_vec(a[AW-1:0]), '0, 1'b0);
      @(negedge clk);
      // R1 R2 R3 R4 R5 R6 R7: contents after table scenarios
      chk(rdata_oe && rdata == ref_mem[a], "R8 readback (R1-7 contents)", rdata, ref_mem[a]);
    end

    drv(rd_vec(6'h04), '0, 1'b0);
    @(negedge clk);
    chk(rdata_oe && rdata == ref_mem[4], "R8 burst read load", rdata, ref_mem[4]);
    drv(cont_vec(1'b0, 1'b1), '0, 1'b0);
    @(negedge clk);
    chk(rdata_oe && rdata == ref_mem[5], "R6 burst read advance", rdata, ref_mem[5]);
    drv(cont_vec(1'b1, 1'b1), '0, 1'b0);
    @(negedge clk);
    chk(rdata_oe && rdata == ref_mem[5], "R5 burst read suspend", rdata, ref_mem[5]);
    drv(cont_vec(1'b1, 1'b1), '0, 1'b1);
    @(negedge clk);
    chk(rdata_oe == 1'b0, "R9 oe_n high during read", {17'b0, rdata_oe}, '0);
    drv(cont_vec(1'b1, 1'b0), 18'h2A5A5, 1'b0);
    ref_mem[5] = 18'h2A5A5;
    @(negedge clk);
    chk(rdata_oe == 1'b0, "R9 no drive after write", {17'b0, rdata_oe}, '0);
    drv(rd_vec(6'h05), '0, 1'b0);
    @(negedge clk);
    chk(rdata_oe && rdata == ref_mem[5], "R2 global write both lanes", rdata, ref_mem[5]);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule